// File: doc/BRIEF.md
# Serial Port Receive/Transmit Flag and Interrupt Unit

This block keeps the status flags of a serial port and raises its two interrupt requests. The receive shifter reports the end of each frame through strobes, with qualifiers for parity and framing errors. The block then decides whether the character is stored or lost and which error flags latch. The frame point at which this happens, and which errors count, depend on a two-bit operating mode. The CPU side is reduced to three kinds of strobe: a read of the receive data register, a write of the transmit data register, and a write of the control register.

The control register holds a receive-interrupt enable and a transmit-interrupt enable. It also has an error-clear bit. Writing zero to that bit drops all three error flags. The shifters, the baud generator and the bus decoding are outside the block.

Top module: `ser_flag_irq`

## Requirements
- R1: After reset the parity, overrun and framing flags and the receive-full flag are 0, the transmit-empty flag is 1, both interrupt enables are 0, and both interrupt outputs are 0.
- R2: In mode 0 (modeSel = 0) a frame completes on `rxStopDone`. At that edge `parErr` latches `rxParityErr`, `frmErr` latches `rxFrameErr`, and when the character is accepted `rxChar` is stored and `rxFull` sets. `rxLastData` has no effect.
- R3: In mode 1 (modeSel = 1) a frame completes on `rxStopDone`, and framing errors latch as in mode 0. `rxParityErr` never sets `parErr`.
- R4: In mode 2 (modeSel = 2) a frame completes on `rxLastData`. `rxStopDone`, `rxParityErr` and `rxFrameErr` have no effect.
- R5: Mode code 3 behaves exactly as mode 0.
- R6: A completing frame while `rxFull` is 1 and no read strobe is present sets `ovrErr`. The new character is discarded, and `rxData` and `rxFull` keep their values.
- R7: `rxDataRd` clears `rxFull` one cycle later. If a frame completes in the same cycle as the read, the new character is stored, `rxFull` stays 1 and no overrun is flagged.
- R8: The error flags clear only on a control write with bit 0 = 0. A control write with bit 0 = 1, or a receive data read, leaves them unchanged.
- R9: When an error flag's set condition and an error-clear write fall in the same cycle, that flag ends at 1.
- R10: `txEmpty` sets on `txShiftLoad` and clears on `txDataWr`. When both occur in the same cycle it ends at 1.
- R11: A control write stores bit 1 as the receive-interrupt enable and bit 2 as the transmit-interrupt enable.
- R12: `rxIrq` is the receive enable ANDed with the OR of `parErr`, `ovrErr`, `frmErr` and `rxFull`. `txIrq` is the transmit enable ANDed with `txEmpty`. Both follow the flags with no further delay.
- R13: `rxDataBad` is 1 exactly while any of the three error flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Operating mode (0, 1, 2; 3 acts as 0) |
| rxStopDone | input | 1 | Final stop bit of a frame detected |
| rxLastData | input | 1 | Last data bit (bit 7) of a frame received |
| rxParityErr | input | 1 | Parity error qualifier for the completing frame |
| rxFrameErr | input | 1 | Framing error qualifier for the completing frame |
| rxChar | input | DATA_W | Character assembled by the receive shifter |
| rxDataRd | input | 1 | Receive data register read strobe |
| txDataWr | input | 1 | Transmit data register write strobe |
| txShiftLoad | input | 1 | Transmit register emptied into the shifter |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 3 | Control write data: bit0 error clear (active 0), bit1 rx enable, bit2 tx enable |
| rxData | output | DATA_W | Receive data register |
| parErr | output | 1 | Parity error flag |
| ovrErr | output | 1 | Overrun error flag |
| frmErr | output | 1 | Framing error flag |
| rxFull | output | 1 | Receive data register full |
| txEmpty | output | 1 | Transmit data register empty |
| rxDataBad | output | 1 | Held data is not valid |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
The assertions treat every strobe as a level sampled once per clock. They place no limit on how strobes combine, so reads, writes, frame completions and clears may land together in any cycle. The mode is taken as the value seen in the cycle of the event, and a mode change is allowed on any clock. The stimulus therefore drives every strobe independently with fixed odds on each cycle, and it steps the mode through all four codes. This makes the same-cycle collisions behind the priority rules occur many times per mode.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;

  typedef enum logic [1:0] {
    MODE_PAR_STOP = 2'd0,
    MODE_ADDR_STOP = 2'd1,
    MODE_LAST_BIT = 2'd2,
    MODE_ALIAS = 2'd3
  } serMode_e;

  localparam int ERR_N = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_OVR = 1;
  localparam int ERR_FRM = 2;

  localparam int CTRL_W = 3;
  localparam int CTRL_ERRCLR_N = 0;
  localparam int CTRL_RX_EN = 1;
  localparam int CTRL_TX_EN = 2;

  typedef struct packed {
    logic             loadChar;
    logic [ERR_N-1:0] errSet;
    logic             errClr;
    logic             fullSet;
    logic             fullClr;
    logic             emptySet;
    logic             emptyClr;
    logic             ctrlLoad;
  } flagStrb_t;

endpackage

// File: rtl/ser_flag_bit.sv
module ser_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setI,
  input  logic clrI,
  output logic q
);
  // set has priority over clear so that no event is lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     q <= RST_VAL;
    else if (setI) q <= 1'b1;
    else if (clrI) q <= 1'b0;
  end
endmodule

// File: rtl/ser_flag_ctrl.sv
module ser_flag_ctrl
  import ser_flag_pkg::*;
(
  input  logic       modeSel0,
  input  logic       modeSel1,
  input  logic       rxStopDone,
  input  logic       rxLastData,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxFullQ,
  input  logic       rxDataRd,
  input  logic       txDataWr,
  input  logic       txShiftLoad,
  input  logic       ctrlWrEn,
  input  logic       ctrlErrClrBit,
  output flagStrb_t  strb
);
  serMode_e mode;
  logic useStop;
  logic parChk;
  logic frmChk;
  logic frameDone;
  logic overrun;

  assign mode = serMode_e'({modeSel1, modeSel0});

  always_comb begin
    useStop = 1'b1;
    parChk  = 1'b1;
    frmChk  = 1'b1;
    unique case (mode)
      MODE_PAR_STOP, MODE_ALIAS: begin
        useStop = 1'b1; parChk = 1'b1; frmChk = 1'b1;
      end
      MODE_ADDR_STOP: begin
        useStop = 1'b1; parChk = 1'b0; frmChk = 1'b1;
      end
      MODE_LAST_BIT: begin
        useStop = 1'b0; parChk = 1'b0; frmChk = 1'b0;
      end
      default: begin
        useStop = 1'b1; parChk = 1'b1; frmChk = 1'b1;
      end
    endcase
  end

  always_comb begin
    frameDone = useStop ? rxStopDone : rxLastData;
    // a read in the same cycle frees the register for the new character
    overrun   = frameDone & rxFullQ & ~rxDataRd;

    strb                 = '0;
    strb.loadChar        = frameDone & ~overrun;
    strb.errSet[ERR_PAR] = frameDone & parChk & rxParityErr;
    strb.errSet[ERR_OVR] = overrun;
    strb.errSet[ERR_FRM] = frameDone & frmChk & rxFrameErr;
    strb.errClr          = ctrlWrEn & ~ctrlErrClrBit;
    strb.fullSet         = frameDone & ~overrun;
    strb.fullClr         = rxDataRd;
    strb.emptySet        = txShiftLoad;
    strb.emptyClr        = txDataWr;
    strb.ctrlLoad        = ctrlWrEn;
  end
endmodule

// File: rtl/ser_flag_dp.sv
module ser_flag_dp
  import ser_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrb_t         strb,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              rxEnIn,
  input  logic              txEnIn,
  output logic [DATA_W-1:0] rxDataQ,
  output logic [ERR_N-1:0]  errQ,
  output logic              rxFullQ,
  output logic              txEmptyQ,
  output logic              rxDataBad,
  output logic              rxIrq,
  output logic              txIrq
);
  logic rxEnQ;
  logic txEnQ;

  for (genvar gi = 0; gi < ERR_N; gi++) begin : g_err
    ser_flag_bit #(.RST_VAL(1'b0)) errBit_i (
      .clk (clk),
      .rstN(rstN),
      .setI(strb.errSet[gi]),
      .clrI(strb.errClr),
      .q   (errQ[gi])
    );
  end

  ser_flag_bit #(.RST_VAL(1'b0)) fullBit_i (
    .clk (clk),
    .rstN(rstN),
    .setI(strb.fullSet),
    .clrI(strb.fullClr),
    .q   (rxFullQ)
  );

  ser_flag_bit #(.RST_VAL(1'b1)) emptyBit_i (
    .clk (clk),
    .rstN(rstN),
    .setI(strb.emptySet),
    .clrI(strb.emptyClr),
    .q   (txEmptyQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxDataQ <= '0;
    else if (strb.loadChar) rxDataQ <= rxChar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnQ <= 1'b0;
      txEnQ <= 1'b0;
    end else if (strb.ctrlLoad) begin
      rxEnQ <= rxEnIn;
      txEnQ <= txEnIn;
    end
  end

  assign rxDataBad = |errQ;
  assign rxIrq     = rxEnQ & (rxDataBad | rxFullQ);
  assign txIrq     = txEnQ & txEmptyQ;
endmodule

// File: rtl/ser_flag_irq.sv
module ser_flag_irq
  import ser_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              rxStopDone,
  input  logic              rxLastData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              rxDataRd,
  input  logic              txDataWr,
  input  logic              txShiftLoad,
  input  logic              ctrlWrEn,
  input  logic [2:0]        ctrlWrData,
  output logic [DATA_W-1:0] rxData,
  output logic              parErr,
  output logic              ovrErr,
  output logic              frmErr,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              rxDataBad,
  output logic              rxIrq,
  output logic              txIrq
);
  flagStrb_t        strb;
  logic [ERR_N-1:0] errQ;

  ser_flag_ctrl ctrl_i (
    .modeSel0     (modeSel[0]),
    .modeSel1     (modeSel[1]),
    .rxStopDone   (rxStopDone),
    .rxLastData   (rxLastData),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr),
    .rxFullQ      (rxFull),
    .rxDataRd     (rxDataRd),
    .txDataWr     (txDataWr),
    .txShiftLoad  (txShiftLoad),
    .ctrlWrEn     (ctrlWrEn),
    .ctrlErrClrBit(ctrlWrData[CTRL_ERRCLR_N]),
    .strb         (strb)
  );

  ser_flag_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rxChar   (rxChar),
    .rxEnIn   (ctrlWrData[CTRL_RX_EN]),
    .txEnIn   (ctrlWrData[CTRL_TX_EN]),
    .rxDataQ  (rxData),
    .errQ     (errQ),
    .rxFullQ  (rxFull),
    .txEmptyQ (txEmpty),
    .rxDataBad(rxDataBad),
    .rxIrq    (rxIrq),
    .txIrq    (txIrq)
  );

  assign parErr = errQ[ERR_PAR];
  assign ovrErr = errQ[ERR_OVR];
  assign frmErr = errQ[ERR_FRM];
endmodule

// File: rtl/ser_flag_chk.sv
module ser_flag_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              rxStopDone,
  input logic              rxLastData,
  input logic              rxDataRd,
  input logic              txDataWr,
  input logic              txShiftLoad,
  input logic              ctrlWrEn,
  input logic              errClrBit,
  input logic [DATA_W-1:0] rxData,
  input logic              parErr,
  input logic              ovrErr,
  input logic              frmErr,
  input logic              rxFull,
  input logic              txEmpty,
  input logic              rxDataBad,
  input logic              rxIrq,
  input logic              txIrq
);
  logic done;
  logic clrWr;
  assign done  = (modeSel == 2'd2) ? rxLastData : rxStopDone;
  assign clrWr = ctrlWrEn & ~errClrBit;

  AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    txShiftLoad |=> txEmpty); // R10
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    txDataWr && !txShiftLoad |=> !txEmpty); // R10
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxDataRd && !done |=> !rxFull); // R7
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    done && rxFull && !rxDataRd |=> ovrErr && rxFull && $stable(rxData)); // R6
  AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd1 || modeSel == 2'd2) && !parErr |=> !parErr); // R3
  AST_NO_FRAMING_MODE2: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == 2'd2 && !frmErr |=> !frmErr); // R4
  AST_FRAMING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr && frmErr |=> frmErr); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr && ovrErr |=> ovrErr); // R8
  AST_TX_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> txEmpty); // R12
  AST_RX_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxFull || rxDataBad)); // R12
endmodule

bind ser_flag_irq ser_flag_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .rxStopDone (rxStopDone),
  .rxLastData (rxLastData),
  .rxDataRd   (rxDataRd),
  .txDataWr   (txDataWr),
  .txShiftLoad(txShiftLoad),
  .ctrlWrEn   (ctrlWrEn),
  .errClrBit  (ctrlWrData[0]),
  .rxData     (rxData),
  .parErr     (parErr),
  .ovrErr     (ovrErr),
  .frmErr     (frmErr),
  .rxFull     (rxFull),
  .txEmpty    (txEmpty),
  .rxDataBad  (rxDataBad),
  .rxIrq      (rxIrq),
  .txIrq      (txIrq)
);

// File: tb/ser_flag_irq_tb_top.sv
`timescale 1ns/1ps
module ser_flag_irq_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = '0;
  logic          rxStopDone = 0, rxLastData = 0, rxParityErr = 0, rxFrameErr = 0;
  logic [DW-1:0] rxChar = '0;
  logic          rxDataRd = 0, txDataWr = 0, txShiftLoad = 0, ctrlWrEn = 0;
  logic [2:0]    ctrlWrData = '0;
  logic [DW-1:0] rxData;
  logic          parErr, ovrErr, frmErr, rxFull, txEmpty, rxDataBad, rxIrq, txIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser_flag_irq #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxStopDone(rxStopDone),
    .rxLastData(rxLastData), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .rxChar(rxChar), .rxDataRd(rxDataRd), .txDataWr(txDataWr),
    .txShiftLoad(txShiftLoad), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .rxData(rxData), .parErr(parErr), .ovrErr(ovrErr), .frmErr(frmErr),
    .rxFull(rxFull), .txEmpty(txEmpty), .rxDataBad(rxDataBad),
    .rxIrq(rxIrq), .txIrq(txIrq)
  );

  // reference model state
  bit mPar, mOvr, mFrm, mFull, mEmpty, mRxEn, mTxEn;
  int mData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPar = 0; mOvr = 0; mFrm = 0; mFull = 0; mEmpty = 1;
      mRxEn = 0; mTxEn = 0; mData = 0;
    end else begin
      bit done, lost, pSet, fSet, clr;
      done = (modeSel == 2) ? rxLastData : rxStopDone;   // R2 R4 R5
      lost = done && mFull && !rxDataRd;                  // R6 R7
      pSet = done && (modeSel == 0 || modeSel == 3) && rxParityErr; // R3
      fSet = done && modeSel != 2 && rxFrameErr;
      clr  = ctrlWrEn && !ctrlWrData[0];                  // R8
      mPar = pSet ? 1 : (clr ? 0 : mPar);                 // R9
      mFrm = fSet ? 1 : (clr ? 0 : mFrm);
      mOvr = lost ? 1 : (clr ? 0 : mOvr);
      if (done && !lost) begin mData = rxChar; mFull = 1; end
      else if (rxDataRd) mFull = 0;
      if (txShiftLoad) mEmpty = 1; else if (txDataWr) mEmpty = 0; // R10
      if (ctrlWrEn) begin mRxEn = ctrlWrData[1]; mTxEn = ctrlWrData[2]; end // R11
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 R3 R5 parErr", parErr, mPar);
    chk("R6 R8 R9 ovrErr", ovrErr, mOvr);
    chk("R2 R4 R9 frmErr", frmErr, mFrm);
    chk("R7 rxFull", rxFull, mFull);
    chk("R2 R6 rxData", rxData, mData);
    chk("R10 txEmpty", txEmpty, mEmpty);
    chk("R13 rxDataBad", rxDataBad, mPar | mOvr | mFrm);
    chk("R11 R12 rxIrq", rxIrq, mRxEn & (mPar | mOvr | mFrm | mFull));
    chk("R11 R12 txIrq", txIrq, mTxEn & mEmpty);
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 parErr", parErr, 0); chk("R1 ovrErr", ovrErr, 0);
    chk("R1 frmErr", frmErr, 0); chk("R1 rxFull", rxFull, 0);
    chk("R1 txEmpty", txEmpty, 1); chk("R1 rxIrq", rxIrq, 0);
    chk("R1 txIrq", txIrq, 0);
    rstN = 1'b1;
    for (int phase = 0; phase < 8; phase++) begin
      modeSel = 2'(phase % 4);
      for (int cyc = 0; cyc < 600; cyc++) begin
        @(negedge clk);
        compareAll();
        rxStopDone  = ($urandom_range(3) == 0);
        rxLastData  = ($urandom_range(3) == 0);
        rxParityErr = $urandom_range(1) != 0;
        rxFrameErr  = $urandom_range(1) != 0;
        rxChar      = DW'($urandom);
        rxDataRd    = ($urandom_range(4) == 0);
        txDataWr    = ($urandom_range(3) == 0);
        txShiftLoad = ($urandom_range(3) == 0);
        ctrlWrEn    = ($urandom_range(7) == 0);
        ctrlWrData  = 3'($urandom);
      end
    end
    @(negedge clk);
    compareAll();
    finished = 1;
    printSummary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=running expected=done");
      printSummary();
      $finish;
    end
  end
endmodule